// File: doc/BRIEF.md
# Register-Mapped Single-Lane SPI Master

This block is an SPI master that software drives through four 32-bit registers on a simple read/write port: a control word, a configuration word, a transmit byte and a receive byte. The serial side has one output data line and one input data line. Each transfer is one byte, sent and received at the same time. Software writes the transmit register to start a byte. It then polls a ready flag in the control word and reads the captured byte from the receive register.

The control word holds one select-enable bit per attached device. The configuration word holds a 5-bit clock divide code, the clock phase and polarity, a length bit and a queue-enable bit. Both of those bits are stored for software but have no effect in this single-byte mode. It also holds a flush bit that clears itself. The divide code, phase and polarity are latched when a byte starts, so the setting in force for a byte cannot change in the middle of it.

Top module: `spi_legacy_master`

## Requirements
- R1: After reset the control word reads 0x0000_0002, with the ready flag at bit 1 and no select enabled. The configuration word and the receive register read 0. Every select output is high and the serial clock is low.
- R2: Offsets are control 0x0, configuration 0x4, transmit 0x8 and receive 0xC. Configuration bits [4:0] (divide code), 5 (length), 6 (phase), 7 (polarity) and 17 (queue enable) read back as written, and all other configuration bits read 0.
- R3: Setting control bit 16+i drives select output i low. Clearing it drives the output high, and the bit reads back as written.
- R4: A write to the transmit register while ready is 1 starts a byte, and ready reads 0 from the next clock on.
- R5: Each serial clock half-period lasts D system clocks, and ready stays 0 for exactly 16·D clocks. D is 2 for codes 0 and 1 and equals the code for codes 2 to 15. For codes 16 to 31, D is twice bits [3:0], and D is 2 when those bits are zero.
- R6: The transmit byte leaves most significant bit first. With phase 0, data is sampled on the leading clock edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R7: When ready returns to 1, receive bits [7:0] hold the byte sampled from the input line, most significant bit first, and bits [31:8] read 0.
- R8: While idle, the serial clock rests at the level of configuration bit 7 (0 = low, 1 = high).
- R9: A write to the transmit register while ready is 0 is ignored: the byte on the wire, its length and the received byte are unchanged.
- R10: Writing 1 to configuration bit 9 makes that bit read 1 in the clock after the write and 0 from the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low device selects |

## Verification
The bench aims at the divider edges: codes 0, 1, 16 and 31 and a random mix between them. A wrong decode would show up as a ready-low window that is not 16·D clocks long. All four phase/polarity combinations run against a bench slave that samples and shifts on the edges the mode names. A design that swapped the edges, or sent the least significant bit first, would receive or transmit a bit-rotated or reversed byte. A transmit write injected mid-byte checks that a busy engine does not reload its shift register. The flush bit is read in the two clocks after it is set, which catches a bit that never clears or never shows.

// File: rtl/spi_lm_pkg.sv
// Package: register offsets, field positions and the divide-code decode
// shared by the register bank, the baud counter and the bench-facing docs.
package spi_lm_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int CODE_W   = 5;
    localparam int DIV_W    = 6;
    localparam int BYTE_W   = 8;
    localparam int EDGE_W   = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_TX   = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_RX   = 4'hC;

    localparam int BIT_READY = 1;
    localparam int BIT_SEL0  = 16;
    localparam int BIT_LEN   = 5;
    localparam int BIT_PHA   = 6;
    localparam int BIT_POL   = 7;
    localparam int BIT_FLUSH = 9;
    localparam int BIT_QEN   = 17;

    // Half-period length in system clocks for a divide code.
    function automatic logic [DIV_W-1:0] code_to_div(input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] d;
        if (code[4]) begin
            if (code[3:0] == 4'd0) d = DIV_W'(2);
            else                   d = {1'b0, code[3:0], 1'b0};
        end else if (code < CODE_W'(2)) begin
            d = DIV_W'(2);
        end else begin
            d = {1'b0, code};
        end
        return d;
    endfunction

endpackage

// File: rtl/spi_lm_regs.sv
// Register bank: decodes bus writes into control/config state, raises a
// start pulse for accepted transmit writes and muxes read data.
// Assumes one write strobe per clock and reads that are combinational.
module spi_lm_regs
    import spi_lm_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ready,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [NUM_CS-1:0] sel_en,
    output logic [CODE_W-1:0] div_code,
    output logic              cfg_pha,
    output logic              cfg_pol,
    output logic              start,
    output logic [BYTE_W-1:0] tx_byte
);

    logic wr_ctrl, wr_cfg, wr_tx;
    logic len_q, qen_q, flush_q;
    logic [BYTE_W-1:0] tx_q;

    // Address decode of the write strobe.
    always_comb begin
        wr_ctrl = bus_wr_en && (bus_addr == OFS_CTRL);
        wr_cfg  = bus_wr_en && (bus_addr == OFS_CFG);
        wr_tx   = bus_wr_en && (bus_addr == OFS_TX);
        start   = wr_tx && ready;
    end

    // Control word: device select enables.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_en <= '0;
        else if (wr_ctrl) sel_en <= bus_wdata[BIT_SEL0 +: NUM_CS];
    end

    // Configuration word: stored fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_code <= '0;
            len_q    <= 1'b0;
            cfg_pha  <= 1'b0;
            cfg_pol  <= 1'b0;
            qen_q    <= 1'b0;
        end else if (wr_cfg) begin
            div_code <= bus_wdata[CODE_W-1:0];
            len_q    <= bus_wdata[BIT_LEN];
            cfg_pha  <= bus_wdata[BIT_PHA];
            cfg_pol  <= bus_wdata[BIT_POL];
            qen_q    <= bus_wdata[BIT_QEN];
        end
    end

    // Flush flag: set by a write, clears itself one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= wr_cfg && bus_wdata[BIT_FLUSH];
    end

    // Transmit holding byte, updated only for accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_q <= '0;
        else if (start) tx_q <= bus_wdata[BYTE_W-1:0];
    end

    assign tx_byte = start ? bus_wdata[BYTE_W-1:0] : tx_q;

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[BIT_READY]          = ready;
                bus_rdata[BIT_SEL0 +: NUM_CS] = sel_en;
            end
            OFS_CFG: begin
                bus_rdata[CODE_W-1:0] = div_code;
                bus_rdata[BIT_LEN]    = len_q;
                bus_rdata[BIT_PHA]    = cfg_pha;
                bus_rdata[BIT_POL]    = cfg_pol;
                bus_rdata[BIT_FLUSH]  = flush_q;
                bus_rdata[BIT_QEN]    = qen_q;
            end
            OFS_TX:  bus_rdata[BYTE_W-1:0] = tx_q;
            OFS_RX:  bus_rdata[BYTE_W-1:0] = rx_byte;
            default: bus_rdata = '0;
        endcase
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |=> (!flush_q || $past(bus_wr_en))); // R10

endmodule

// File: rtl/spi_lm_baud.sv
// Baud counter: latches the half-period length at start and pulses tick
// once every D clocks while a byte is in flight.
// Assumes start only arrives while idle.
module spi_lm_baud
    import spi_lm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy,
    input  logic [CODE_W-1:0] div_code,
    output logic              tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = busy && (cnt_q == div_q - DIV_W'(1));

    // Latch divider at start; count while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(2);
            cnt_q <= '0;
        end else if (start) begin
            div_q <= code_to_div(div_code);
            cnt_q <= '0;
        end else if (busy) begin
            cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (div_q >= DIV_W'(2))); // R5

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q < div_q)); // R5

endmodule

// File: rtl/spi_lm_shift.sv
// Shift engine: runs sixteen clock edges per byte, driving data out MSB
// first and sampling data in on the edge chosen by the phase.
// Assumes tick comes from the baud counter and start only while idle.
module spi_lm_shift
    import spi_lm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              cfg_pha,
    input  logic              cfg_pol,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam logic [EDGE_W-1:0] LAST_EDGE = '1;

    logic              busy_q, sclk_q, pha_q;
    logic [EDGE_W-1:0] edge_q;
    logic [BYTE_W-1:0] tx_q, rx_q, din_q;
    logic              lead, smp, shift_out;
    logic [BYTE_W-1:0] rx_next;

    // Classify the coming edge as leading/trailing and sample/shift.
    always_comb begin
        lead      = (edge_q[0] == 1'b0);
        smp       = lead ^ pha_q;
        shift_out = !smp && !(lead && edge_q == '0);
        rx_next   = {rx_q[BYTE_W-2:0], miso};
    end

    // Edge sequencer with transmit and receive shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            pha_q  <= 1'b0;
            edge_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            din_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            pha_q  <= cfg_pha;
            sclk_q <= cfg_pol;
            edge_q <= '0;
            tx_q   <= tx_byte;
            rx_q   <= '0;
        end else if (busy_q && tick) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + EDGE_W'(1);
            if (smp)       rx_q <= rx_next;
            if (shift_out) tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            if (edge_q == LAST_EDGE) begin
                busy_q <= 1'b0;
                din_q  <= smp ? rx_next : rx_q;
            end
        end else if (!busy_q) begin
            sclk_q <= cfg_pol;
        end
    end

    assign busy    = busy_q;
    assign sclk    = sclk_q;
    assign mosi    = tx_q[BYTE_W-1];
    assign rx_byte = din_q;

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R9

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_q); // R4

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> (sclk_q == $past(cfg_pol))); // R8

    AST_LAST_EDGE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && tick && edge_q == LAST_EDGE) |=> !busy_q); // R5

    AST_RX_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && !$fell(busy_q)) |-> $stable(din_q)); // R7

endmodule

// File: rtl/spi_legacy_master.sv
// Top level: register bank, baud counter and shift engine of a one-byte,
// single-lane SPI master. Assumes a single clock domain for bus and engine.
module spi_legacy_master
    import spi_lm_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);

    logic              busy, start, tick, cfg_pha, cfg_pol;
    logic [NUM_CS-1:0] sel_en;
    logic [CODE_W-1:0] div_code;
    logic [BYTE_W-1:0] tx_byte, rx_byte;

    spi_lm_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ready(!busy), .rx_byte(rx_byte),
        .sel_en(sel_en), .div_code(div_code),
        .cfg_pha(cfg_pha), .cfg_pol(cfg_pol),
        .start(start), .tx_byte(tx_byte)
    );

    spi_lm_baud u_baud (
        .clk(clk), .rst_n(rst_n),
        .start(start), .busy(busy),
        .div_code(div_code), .tick(tick)
    );

    spi_lm_shift u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(start), .tick(tick), .tx_byte(tx_byte),
        .cfg_pha(cfg_pha), .cfg_pol(cfg_pol), .miso(spi_miso),
        .busy(busy), .sclk(spi_sclk), .mosi(spi_mosi),
        .rx_byte(rx_byte)
    );

    // Select outputs are active low.
    assign spi_cs_n = ~sel_en;

    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && bus_addr == OFS_CTRL) |=> $stable(spi_cs_n)); // R3

endmodule

// File: tb/spi_legacy_master_tb.sv
module spi_legacy_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [NCS-1:0] spi_cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench slave state.
    logic [7:0] sl_tx, sl_rx;
    bit sl_active = 0;
    bit sl_pha = 0, sl_pol = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_legacy_master #(.NUM_CS(NCS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // Slave: samples and shifts on the edges the mode names.
    always @(spi_sclk) begin
        if (sl_active) begin
            if ((spi_sclk != sl_pol) ^ sl_pha) begin
                sl_rx = {sl_rx[6:0], spi_mosi};
            end else if (sl_pha) begin
                spi_miso = sl_tx[7];
                sl_tx = {sl_tx[6:0], 1'b0};
            end else begin
                sl_tx = {sl_tx[6:0], 1'b0};
                spi_miso = sl_tx[7];
            end
        end
    end

    function automatic int exp_div(input logic [4:0] code);
        if (code[4]) return (code[3:0] == 0) ? 2 : 2 * int'(code[3:0]);
        if (code < 2) return 2;
        return int'(code);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic xfer(input logic [4:0] code, input bit pha, input bit pol,
                        input logic [7:0] txb, input logic [7:0] slb, input bit ign);
        logic [31:0] r;
        int n;
        bit rdy;
        bus_write(4'h4, {24'h0, pol, pha, 1'b0, code});
        repeat (2) @(negedge clk);
        check("R8 idle sclk", {31'h0, spi_sclk}, {31'h0, pol});
        sl_tx = slb; sl_rx = 8'h00; sl_pha = pha; sl_pol = pol;
        if (!pha) spi_miso = slb[7];
        sl_active = 1;
        bus_write(4'h8, {24'h0, txb});
        bus_read(4'h0, r);
        rdy = r[1];
        check("R4 ready low after write", {31'h0, rdy}, 32'h0);
        n = 0;
        while (!rdy && n < 5000) begin
            n++;
            if (ign && n == 3) begin
                bus_addr = 4'h8; bus_wdata = {24'h0, ~txb}; bus_wr_en = 1'b1;
            end
            @(negedge clk);
            bus_wr_en = 1'b0;
            bus_read(4'h0, r);
            rdy = r[1];
        end
        sl_active = 0;
        check("R5 ready-low length", n, 16 * exp_div(code));
        bus_read(4'hC, r);
        check(ign ? "R9 rx after ignored write" : "R7 rx byte", r, {24'h0, slb});
        check(ign ? "R9 wire byte after ignored write" : "R6 slave got byte",
              {24'h0, sl_rx}, {24'h0, txb});
        check("R8 sclk back to idle", {31'h0, spi_sclk}, {31'h0, pol});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(4'h0, r); check("R1 ctrl reset", r, 32'h0000_0002);
        bus_read(4'h4, r); check("R1 cfg reset", r, 32'h0);
        bus_read(4'hC, r); check("R1 rx reset", r, 32'h0);
        check("R1 selects high", {28'h0, spi_cs_n}, 32'hF);
        check("R1 sclk low", {31'h0, spi_sclk}, 32'h0);

        // R2 config readback
        bus_write(4'h4, 32'hFFFD_FD55 | 32'h0002_00A0);
        bus_read(4'h4, r); check("R2 cfg readback", r, 32'h0002_00F5);
        bus_write(4'h4, 32'h0000_0000);
        bus_read(4'h4, r); check("R2 cfg cleared", r, 32'h0);

        // R3 selects
        bus_write(4'h0, 32'h0005_0000);
        check("R3 select outputs", {28'h0, spi_cs_n}, 32'hA);
        bus_read(4'h0, r); check("R3 ctrl readback", r, 32'h0005_0002);
        bus_write(4'h0, 32'h0001_0000);
        check("R3 select cleared", {28'h0, spi_cs_n}, 32'hE);

        // R10 flush self-clear
        bus_write(4'h4, 32'h0000_0200);
        bus_read(4'h4, r); check("R10 flush visible", {31'h0, r[9]}, 32'h1);
        @(negedge clk);
        bus_read(4'h4, r); check("R10 flush cleared", {31'h0, r[9]}, 32'h0);

        // Directed divider corners and modes (R5, R6, R7)
        xfer(5'h00, 0, 0, 8'hA5, 8'h3C, 0);
        xfer(5'h01, 1, 0, 8'h81, 8'hC3, 0);
        xfer(5'h10, 0, 1, 8'h7E, 8'h01, 0);
        xfer(5'h1F, 1, 1, 8'h96, 8'h80, 0);
        xfer(5'h05, 0, 0, 8'h01, 8'hFE, 0);
        xfer(5'h13, 1, 0, 8'hF0, 8'h0F, 0);

        // R9 ignored write mid-byte
        xfer(5'h04, 0, 1, 8'h5A, 8'hE7, 1);
        xfer(5'h02, 1, 1, 8'hC9, 8'h36, 1);

        // Random mix
        for (int i = 0; i < 24; i++) begin
            xfer(5'($urandom % 32), 1'($urandom), 1'($urandom),
                 8'($urandom), 8'($urandom), 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule